// File: doc/BRIEF.md
# Intensity Band Outline Filter

This block takes a raster stream of grayscale pixels and produces, one pixel at a time, the outline of the image regions whose intensity lies inside a band around a reference level. Each pixel first becomes one mask bit: 1 when it lies between the reference minus a tolerance and the reference plus that tolerance, and 0 otherwise. A binary 3x3 morphology stage then sets an outline bit wherever the dilated mask and the eroded mask differ. The outline traces the border of every in-band region, one pixel wide on each side of the border.

A frame is `FRAME_H` rows of exactly `LINE_W` pixels. The first pixel carries `pix_sof` and the last pixel of every row carries `pix_eol`. The reference and tolerance are free-running inputs. The block takes them on the start-of-frame pixel, so a new selection acts from the next frame on, and no frame ever mixes two bands. The outline stream runs one row plus one pixel behind the input. After the last input pixel of a frame, the block emits the remaining outline bits by itself. For this to work, the source must leave at least `LINE_W+1` idle clocks before the next frame starts.

Top module: `band_outline_filter`

## Requirements
- R1: The band limits are lo = max(ref−tol, 0) and hi = min(ref+tol, 2^PIX_W−1). They saturate instead of wrapping. A pixel's mask bit is 1 exactly when lo ≤ pixel ≤ hi, with both limits inclusive.
- R2: The band limits are taken from `ref_level` and `tol_level` on the valid pixel that carries `pix_sof`. They are used for every pixel of that frame. Changes to `ref_level` or `tol_level` at any other time have no effect until the next start-of-frame pixel.
- R3: A pixel is accepted on every clock where `pix_valid` is high, with no idle clock required between pixels. Its mask bit is registered exactly one clock later.
- R4: The outline bit of a pixel is the XOR of two values over its 3x3 neighbourhood: dilation, which is 1 when any of the nine mask bits is 1, and erosion, which is 1 only when all nine are 1.
- R5: Neighbourhood positions above the first row, below the last row, left of column 0 or right of column LINE_W−1 count as mask 0. An in-band pixel on the image border is therefore always an outline pixel.
- R6: Outline bits leave in raster order. Let N be LINE_W×FRAME_H and let e be the clock edge that samples input pixel k+LINE_W+1. When k+LINE_W+1 < N, the bit for raster index k is presented right after edge e+1. Otherwise it is presented right after the (k+LINE_W+3−N)-th edge following the edge that samples the last pixel.
- R7: `out_eol` is high exactly on outline bits of column LINE_W−1. `out_edge` and `out_eol` are low whenever `out_valid` is low.
- R8: After the last pixel of a frame, the last LINE_W+1 outline bits are produced on consecutive clocks without further input, given at least LINE_W+1 idle clocks before the next frame.
- R9: Each frame yields exactly LINE_W×FRAME_H outline bits. Data left over from an earlier frame never produces output and never enters the neighbourhood of the new frame.
- R10: While reset is high and on the first clock after it, `out_valid`, `out_eol` and `out_edge` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Input pixel present this clock |
| pix_sof | input | 1 | First pixel of a frame; band limits are taken here |
| pix_eol | input | 1 | Last pixel of a row |
| pix_data | input | PIX_W | Grayscale intensity |
| ref_level | input | PIX_W | Reference intensity of the band |
| tol_level | input | PIX_W | Half width of the band |
| out_valid | output | 1 | Outline bit present this clock |
| out_eol | output | 1 | Outline bit belongs to the last column |
| out_edge | output | 1 | Outline bit: 1 on region borders |

## Verification
The mask bit is due one clock after its pixel is sampled. The outline bit of raster index k follows the edge that samples pixel k+LINE_W+1 by one clock, or, near the frame end, follows the last pixel by a fixed count of drain clocks. The bench drives each input on a falling edge and records the number of the rising edge that will sample it. It captures every outline bit on the falling edge after it appears, together with that edge number, and compares the number with the one computed from the R6 formula. Value and position are checked against a mask and 3x3 neighbourhood rebuilt in the bench from the pixels and the band taken on the start-of-frame pixel. Random idle gaps and back-to-back pixels move these due edges around.

// File: rtl/band_outline_pkg.sv
package band_outline_pkg;

    // One registered mask sample leaving the threshold stage
    typedef struct packed {
        logic vld;
        logic sof;
        logic eol;
        logic hit;
    } mask_beat_t;

    // One column of the binary 3x3 window, top row first
    typedef struct packed {
        logic top;
        logic mid;
        logic bot;
    } wcol_t;

    function automatic logic [8:0] win_flat(input wcol_t l, input wcol_t m, input wcol_t r);
        return {l, m, r};
    endfunction

    // Erosion of a binary window: one compare against all-ones
    function automatic logic win_erode(input logic [8:0] w);
        return w == 9'h1FF;
    endfunction

    // Dilation of a binary window: one compare against all-zeros
    function automatic logic win_dilate(input logic [8:0] w);
        return w != 9'h000;
    endfunction

endpackage

// File: rtl/bo_bounds.sv
module bo_bounds #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [PIX_W-1:0] ref_i,
    input  logic [PIX_W-1:0] tol_i,
    output logic [PIX_W-1:0] lo_o,
    output logic [PIX_W-1:0] hi_o
);
    localparam logic [PIX_W-1:0] PMAX = '1;

    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] lo_n, hi_n;
    logic [PIX_W-1:0] lo_q, hi_q;

    // Saturating limits, computed without a clock
    always_comb begin
        sum  = {1'b0, ref_i} + {1'b0, tol_i};
        hi_n = sum[PIX_W] ? PMAX : sum[PIX_W-1:0];
        lo_n = (ref_i > tol_i) ? (ref_i - tol_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (take) begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // The start-of-frame pixel already uses the fresh limits
    assign lo_o = take ? lo_n : lo_q;
    assign hi_o = take ? hi_n : hi_q;
endmodule

// File: rtl/bo_slicer.sv
module bo_slicer
    import band_outline_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_eol,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [PIX_W-1:0] lo_i,
    input  logic [PIX_W-1:0] hi_i,
    output mask_beat_t       beat_o
);
    logic in_band;

    assign in_band = (pix_data >= lo_i) && (pix_data <= hi_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.vld <= pix_valid;
            beat_o.sof <= pix_valid & pix_sof;
            beat_o.eol <= pix_valid & pix_eol;
            beat_o.hit <= pix_valid & in_band;
        end
    end
endmodule

// File: rtl/bo_window.sv
module bo_window
    import band_outline_pkg::*;
#(
    parameter int LINE_W  = 32,
    parameter int FRAME_H = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  mask_beat_t beat_i,
    output logic       out_valid,
    output logic       out_eol,
    output logic       out_edge
);
    localparam int CW  = $clog2(LINE_W);
    localparam int RW  = $clog2(FRAME_H + 2);
    localparam int DRW = $clog2(LINE_W + 2);
    localparam int NLB = 2;

    localparam logic [CW-1:0]  COL_LAST  = CW'(LINE_W - 1);
    localparam logic [CW-1:0]  COL_ONE   = CW'(1);
    localparam logic [RW-1:0]  ROW_ONE   = RW'(1);
    localparam logic [RW-1:0]  ROW_TWO   = RW'(2);
    localparam logic [RW-1:0]  ROW_END   = RW'(FRAME_H);
    localparam logic [RW-1:0]  ROW_LAST  = RW'(FRAME_H - 1);
    localparam logic [DRW-1:0] DRAIN_LEN = DRW'(LINE_W + 1);

    // Position of the next column to enter the window
    logic [RW-1:0]  row_q, cur_row, nxt_row;
    logic [CW-1:0]  col_q, cur_col, nxt_col;
    logic [DRW-1:0] drain_q;

    logic push, push_bit, real_px, wrap, last_px, emit;

    // lb[0] holds the previous row, lb[1] the row before it
    logic [LINE_W-1:0] lb [NLB];
    logic [NLB:0]      lb_in;

    wcol_t wm_q, wr_q, col_in, gl, gr;
    logic [8:0] win;
    logic       ero, dil;

    always_comb begin
        real_px  = beat_i.vld;
        push     = real_px || (drain_q != '0);
        push_bit = real_px & beat_i.hit;
        cur_row  = (real_px && beat_i.sof) ? '0 : row_q;
        cur_col  = (real_px && beat_i.sof) ? '0 : col_q;
        wrap     = real_px ? beat_i.eol : (cur_col == COL_LAST);
        nxt_row  = wrap ? cur_row + ROW_ONE : cur_row;
        nxt_col  = wrap ? '0 : cur_col + COL_ONE;
        last_px  = real_px && beat_i.eol && (cur_row == ROW_LAST);
    end

    // Line buffer chain, one stage per stored row
    assign lb_in[0] = push_bit;
    generate
        for (genvar s = 0; s < NLB; s++) begin : g_lb
            assign lb_in[s+1] = lb[s][cur_col];
            always_ff @(posedge clk) begin
                if (rst) begin
                    lb[s] <= '0;
                end else if (push) begin
                    lb[s][cur_col] <= lb_in[s];
                end
            end
        end
    endgenerate

    // New column, with rows outside the frame forced to zero
    always_comb begin
        col_in.top = lb_in[2] & (cur_row >= ROW_TWO);
        col_in.mid = lb_in[1] & (cur_row >= ROW_ONE) & (cur_row <= ROW_END);
        col_in.bot = push_bit & (cur_row < ROW_END);
        gl   = (cur_col == COL_ONE) ? wcol_t'('0) : wm_q;
        gr   = (cur_col == '0)      ? wcol_t'('0) : col_in;
        win  = win_flat(gl, wr_q, gr);
        ero  = win_erode(win);
        dil  = win_dilate(win);
        emit = push && ((cur_row >= ROW_TWO) || ((cur_row == ROW_ONE) && (cur_col != '0)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q     <= '0;
            col_q     <= '0;
            drain_q   <= '0;
            wm_q      <= '0;
            wr_q      <= '0;
            out_valid <= 1'b0;
            out_eol   <= 1'b0;
            out_edge  <= 1'b0;
        end else begin
            if (push) begin
                row_q <= nxt_row;
                col_q <= nxt_col;
                wm_q  <= wr_q;
                wr_q  <= col_in;
            end
            if (last_px) begin
                drain_q <= DRAIN_LEN;
            end else if (drain_q != '0) begin
                drain_q <= drain_q - DRW'(1);
            end
            out_valid <= emit;
            out_eol   <= emit & (cur_col == '0);
            out_edge  <= emit & (dil ^ ero);
        end
    end
endmodule

// File: rtl/band_outline_filter.sv
module band_outline_filter
    import band_outline_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int LINE_W  = 32,
    parameter int FRAME_H = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_eol,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [PIX_W-1:0] ref_level,
    input  logic [PIX_W-1:0] tol_level,
    output logic             out_valid,
    output logic             out_eol,
    output logic             out_edge
);
    logic             take;
    logic [PIX_W-1:0] band_lo, band_hi;
    mask_beat_t       m_beat;

    assign take = pix_valid & pix_sof;

    bo_bounds #(.PIX_W(PIX_W)) u_bounds (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .ref_i (ref_level),
        .tol_i (tol_level),
        .lo_o  (band_lo),
        .hi_o  (band_hi)
    );

    bo_slicer #(.PIX_W(PIX_W)) u_slicer (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_sof   (pix_sof),
        .pix_eol   (pix_eol),
        .pix_data  (pix_data),
        .lo_i      (band_lo),
        .hi_i      (band_hi),
        .beat_o    (m_beat)
    );

    bo_window #(.LINE_W(LINE_W), .FRAME_H(FRAME_H)) u_window (
        .clk       (clk),
        .rst       (rst),
        .beat_i    (m_beat),
        .out_valid (out_valid),
        .out_eol   (out_eol),
        .out_edge  (out_edge)
    );
endmodule

// File: rtl/band_outline_chk.sv
module band_outline_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic             pix_sof,
    input logic [PIX_W-1:0] pix_data,
    input logic [PIX_W-1:0] ref_level,
    input logic [PIX_W-1:0] tol_level,
    input logic [PIX_W-1:0] band_lo,
    input logic [PIX_W-1:0] band_hi,
    input logic             m_vld,
    input logic             m_hit,
    input logic             out_valid,
    input logic             out_eol,
    input logic             out_edge
);
    localparam int MAXV = (1 << PIX_W) - 1;

    function automatic logic band_hit(input logic [PIX_W-1:0] p,
                                      input logic [PIX_W-1:0] r,
                                      input logic [PIX_W-1:0] t);
        int lo, hi;
        lo = int'(r) - int'(t);
        hi = int'(r) + int'(t);
        if (lo < 0)    lo = 0;
        if (hi > MAXV) hi = MAXV;
        return (int'(p) >= lo) && (int'(p) <= hi);
    endfunction

    // R1: start-of-frame pixel classified against the saturated band
    p_sof_band_r1: assert property (@(posedge clk) disable iff (rst)
        pix_valid && pix_sof |=> m_hit == band_hit($past(pix_data), $past(ref_level), $past(tol_level)));

    // R1: saturated limits never cross
    p_lo_le_hi_r1: assert property (@(posedge clk) disable iff (rst)
        band_lo <= band_hi);

    // R2: limits move only on a start-of-frame pixel
    p_band_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(pix_valid && pix_sof) |=> (pix_valid && pix_sof) || ($stable(band_lo) && $stable(band_hi)));

    // R3: every accepted pixel yields a mask bit one clock later
    p_mask_lat_r3: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> m_vld);

    // R7: flags only accompany a valid outline bit
    p_eol_gated_r7: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> out_valid);

    p_edge_gated_r7: assert property (@(posedge clk) disable iff (rst)
        out_edge |-> out_valid);
endmodule

bind band_outline_filter band_outline_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_data  (pix_data),
    .ref_level (ref_level),
    .tol_level (tol_level),
    .band_lo   (band_lo),
    .band_hi   (band_hi),
    .m_vld     (m_beat.vld),
    .m_hit     (m_beat.hit),
    .out_valid (out_valid),
    .out_eol   (out_eol),
    .out_edge  (out_edge)
);

// File: tb/sim_band_outline_filter.sv
module sim_band_outline_filter;
    localparam int PW   = 8;
    localparam int TW   = 8;
    localparam int TH   = 5;
    localparam int NPIX = TW * TH;
    localparam int OBN  = NPIX + 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          pix_valid, pix_sof, pix_eol;
    logic [PW-1:0] pix_data, ref_level, tol_level;
    logic          out_valid, out_eol, out_edge;

    always #4 clk = ~clk;   // 125 MHz

    band_outline_filter #(.PIX_W(PW), .LINE_W(TW), .FRAME_H(TH)) u0 (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_data(pix_data), .ref_level(ref_level),
        .tol_level(tol_level), .out_valid(out_valid), .out_eol(out_eol),
        .out_edge(out_edge)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [PW-1:0] fr [NPIX];
    int            in_edge [NPIX];
    logic          ob_bit  [OBN];
    logic          ob_eol  [OBN];
    int            ob_edge [OBN];
    int            ob_n = 0;

    // Capture every outline bit with the number of the edge that produced it
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (ob_n < OBN) begin
                ob_bit[ob_n]  = out_edge;
                ob_eol[ob_n]  = out_eol;
                ob_edge[ob_n] = cyc;
            end
            ob_n = ob_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lo_of(input int r, input int t);
        return (r - t < 0) ? 0 : r - t;
    endfunction

    function automatic int hi_of(input int r, input int t);
        return (r + t > 255) ? 255 : r + t;
    endfunction

    function automatic int mask_at(input int r, input int c, input int lo, input int hi);
        if (r < 0 || r >= TH || c < 0 || c >= TW) return 0;
        return (int'(fr[r*TW+c]) >= lo && int'(fr[r*TW+c]) <= hi) ? 1 : 0;
    endfunction

    function automatic int outline_at(input int k, input int lo, input int hi);
        int any_b = 0;
        int all_b = 1;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int m = mask_at(k / TW + dr, k % TW + dc, lo, hi);
                any_b = any_b | m;
                all_b = all_b & m;
            end
        end
        return any_b ^ all_b;
    endfunction

    function automatic logic [PW-1:0] gen_px(input int mode, input int rf, input int tl, input int cval);
        int v;
        case (mode)
            0: v = int'($urandom % 256);
            1: v = rf - tl - 2 + int'($urandom % (2 * tl + 5));
            2: v = cval;
            default: v = (($urandom % 6) == 0) ? rf : rf + tl + 40;
        endcase
        if (v < 0)   v = 0;
        if (v > 255) v = 255;
        return PW'(v);
    endfunction

    task automatic run_frame(input string tag, input int mode, input int rf, input int tl,
                             input int cval, input int gapmax, input bit mid_change);
        int lo = lo_of(rf, tl);
        int hi = hi_of(rf, tl);
        ob_n = 0;
        // Band inputs hold unrelated values until the start-of-frame pixel (R2)
        ref_level = PW'($urandom % 256);
        tol_level = PW'($urandom % 256);
        for (int i = 0; i < NPIX; i++) fr[i] = gen_px(mode, rf, tl, cval);
        for (int i = 0; i < NPIX; i++) begin
            int g = (gapmax == 0) ? 0 : int'($urandom % (gapmax + 1));
            pix_valid = 1'b0;
            repeat (g) @(negedge clk);
            if (i == 0) begin
                ref_level = PW'(rf);
                tol_level = PW'(tl);
            end else if (mid_change && i == NPIX / 2) begin
                ref_level = PW'($urandom % 256);
                tol_level = PW'($urandom % 64);
            end
            pix_valid  = 1'b1;
            pix_sof    = (i == 0);
            pix_eol    = ((i % TW) == TW - 1);
            pix_data   = fr[i];
            in_edge[i] = cyc + 1;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        pix_eol   = 1'b0;
        if (!mid_change) begin
            ref_level = PW'($urandom % 256);
            tol_level = PW'($urandom % 256);
        end
        repeat (TW + 8) @(negedge clk);
        // R9: one outline bit per pixel, no more
        chk({"R9 count ", tag}, ob_n, NPIX);
        for (int k = 0; k < NPIX && k < ob_n; k++) begin
            int src = k + TW + 1;
            int exp_edge = (src < NPIX) ? in_edge[src] + 1 : in_edge[NPIX-1] + src - NPIX + 2;
            int r = k / TW;
            int c = k % TW;
            bit border = (r == 0 || r == TH - 1 || c == 0 || c == TW - 1);
            chk({border ? "R5 border " : "R4 interior ", tag}, int'(ob_bit[k]), outline_at(k, lo, hi));
            chk({"R7 eol ", tag}, int'(ob_eol[k]), (c == TW - 1) ? 1 : 0);
            chk({(src < NPIX) ? "R6 timing " : "R8 drain timing ", tag}, ob_edge[k], exp_edge);
        end
    endtask

    always @(posedge clk) begin
        if (!done && cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed      = int'($urandom(32'd1234));
        rst       = 1'b1;
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        pix_eol   = 1'b0;
        pix_data  = '0;
        ref_level = '0;
        tol_level = '0;
        repeat (3) @(negedge clk);
        // R10: quiet outputs during reset
        chk("R10 valid in reset", int'(out_valid), 0);
        chk("R10 edge in reset", int'(out_edge), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 valid after reset", int'(out_valid), 0);
        chk("R10 eol after reset", int'(out_eol), 0);

        run_frame("R1 R3 random wide band", 0, 128, 60, 0, 3, 1'b0);
        run_frame("R3 back-to-back near band", 1, 100, 10, 0, 0, 1'b0);
        run_frame("R1 upper saturation in", 2, 250, 20, 255, 1, 1'b0);
        run_frame("R1 below lower limit", 2, 250, 20, 229, 1, 1'b0);
        run_frame("R1 lower saturation in", 2, 3, 10, 0, 0, 1'b0);
        run_frame("R1 zero tolerance hit", 2, 77, 0, 77, 2, 1'b0);
        run_frame("R1 zero tolerance miss", 2, 77, 0, 78, 0, 1'b0);
        run_frame("R2 mid-frame band change", 1, 60, 12, 0, 2, 1'b1);
        run_frame("R4 R5 sparse regions", 3, 90, 4, 0, 2, 1'b0);
        run_frame("R6 R8 dense back-to-back", 1, 200, 5, 0, 0, 1'b0);
        for (int f = 0; f < 4; f++) begin
            run_frame("R4 random mix", 1, int'($urandom % 256), int'($urandom % 40), 0, f, 1'b0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule